// File: doc/BRIEF.md
# Multiplexer receive queue with fill alarm

This block collects characters from the eight lines of an asynchronous terminal multiplexer into one shared first-in first-out queue. Each entry is tagged with the number of its line and held until a host reads it through a read-only receive word. A received break is queued as a marker entry that carries no character. Each line has a one-entry holding slot. When several lines deliver at once, the slots are drained into the queue one per cycle, lowest line first.

The host sees two flags. The done flag shows that data is waiting. The alarm flag fires once when the backlog reaches a threshold. After firing, the alarm stays disarmed until a read finds the queue empty or a clear is issued. The receive interrupt request follows the done flag or the alarm flag, depending on an alarm-enable input, and is gated by a receive interrupt enable. Receive enables are set per line through a line parameter write. A master scan enable turns the whole receive path on or off.

Top module: `term_rx_queue`

## Requirements
- R1: A read word holds the character in bits 7:0, the line number in bits 10:8 and the valid flag in bit 15, with bits 14, 12 and 11 at zero. A read of a queued character on line L with code C returns 16'h8000 | L<<8 | C.
- R2: A break on line L is queued as a valid entry with the frame-error bit 13 set and a zero character: 16'hA000 | L<<8.
- R3: A line parameter write takes the line number from data bits 2:0 and sets that line's receive enable from bit 12. Characters on a line whose enable is clear are ignored. All enables are clear after reset and after a clear.
- R4: Characters that arrive on several lines in the same cycle are all kept and enter the queue in ascending line order.
- R5: Entries leave the queue in arrival order. Each read returns the oldest entry and removes it. The read word holds its value until the next read.
- R6: The done output is high exactly when the queue is non-empty and master scan is enabled.
- R7: When armed, the alarm output sets in the cycle the queue count reaches ALARM_LEVEL (16), and setting it disarms the alarm.
- R8: Any read clears the alarm output. A read that finds the queue empty while scan is enabled re-arms the alarm, and so does a clear.
- R9: While master scan is disabled, a read returns zero and removes nothing, and arriving characters are ignored.
- R10: The interrupt request equals the receive interrupt enable AND (the alarm output when the alarm enable is set, otherwise the done output).
- R11: A character granted while the queue holds DEPTH (64) entries is dropped and sets the sticky overflow output. The queue keeps its first 64 entries.
- R12: A clear empties the queue and zeroes the read word, the alarm and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clear pulse: empties queue, drops enables, re-arms alarm |
| scan_en | input | 1 | Master scan enable |
| rx_ie | input | 1 | Receive interrupt enable |
| alarm_ie | input | 1 | Selects the alarm (1) or done (0) as interrupt source |
| lpr_wr | input | 1 | Line parameter write strobe |
| lpr_data | input | 16 | Line parameter word: line in 2:0, receive enable in 12 |
| line_valid | input | 8 | Per-line character strobe |
| line_char | input | 64 | Per-line character, line i in bits 8i+7:8i |
| line_brk | input | 8 | Per-line break marker, qualifies line_valid |
| rbuf_rd | input | 1 | Read strobe for the receive word |
| rbuf_data | output | 16 | Receive word from the last read |
| done | output | 1 | Data waiting |
| alarm | output | 1 | Fill alarm flag |
| overflow | output | 1 | Sticky dropped-character flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench drives arrivals on three lines in one cycle. A picker that served the highest line first, or dropped the later slots, would return the words out of order or short. It fills the queue past the threshold, reads one entry and refills to the threshold. A design that re-armed on every read would raise the alarm a second time. It then reads the queue dry and once more. A design that missed the re-arm would stay silent on the next fill. It also overfills to 65 entries, where an overwriting queue would corrupt the oldest word or leave overflow clear. Finally it reads with scan disabled, where a design that popped anyway would lose the pending character.

// File: rtl/term_rx_pkg.sv
package term_rx_pkg;
  localparam int NLINES = 8;
  localparam int LINE_W = $clog2(NLINES);
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } rx_ent_t;

  localparam int ENT_W = $bits(rx_ent_t);

  // host-visible word: valid 15, frame error 13, line 10:8, char 7:0
  function automatic logic [15:0] rbuf_word(rx_ent_t e);
    return {1'b1, 1'b0, e.brk, 2'b00, e.line, e.ch};
  endfunction

  function automatic logic level_reached(int unsigned cnt, int unsigned lvl);
    return cnt >= lvl;
  endfunction
endpackage

// File: rtl/rx_line_slots.sv
module rx_line_slots
  import term_rx_pkg::*;
#(
  parameter int NL = NLINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             scan_en,
  input  logic             lpr_wr,
  input  logic [LINE_W-1:0] lpr_line,
  input  logic             lpr_en,
  input  logic [NL-1:0]    line_valid,
  input  logic [NL*CHAR_W-1:0] line_char,
  input  logic [NL-1:0]    line_brk,
  input  logic [NL-1:0]    grant,
  output logic [NL-1:0]    pend_v,
  output logic [NL*CHAR_W-1:0] pend_char,
  output logic [NL-1:0]    pend_brk
);
  logic [NL-1:0] rcve;

  for (genvar i = 0; i < NL; i++) begin : g_slot
    logic arrive;
    assign arrive = line_valid[i] && rcve[i] && scan_en;

    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        rcve[i]   <= 1'b0;
        pend_v[i] <= 1'b0;
        pend_brk[i] <= 1'b0;
        pend_char[i*CHAR_W +: CHAR_W] <= '0;
      end else begin
        if (lpr_wr && (lpr_line == LINE_W'(i))) rcve[i] <= lpr_en;
        if (arrive) begin
          pend_v[i]   <= 1'b1;
          pend_brk[i] <= line_brk[i];
          pend_char[i*CHAR_W +: CHAR_W] <=
            line_brk[i] ? '0 : line_char[i*CHAR_W +: CHAR_W];
        end else if (grant[i]) begin
          pend_v[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rx_pick_lowest.sv
module rx_pick_lowest
  import term_rx_pkg::*;
#(
  parameter int NL = NLINES
) (
  input  logic [NL-1:0]     req,
  output logic [NL-1:0]     grant,
  output logic [LINE_W-1:0] idx,
  output logic              any
);
  always_comb begin
    idx = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (req[i]) idx = LINE_W'(i);
    end
  end

  assign grant = req & ~(req - NL'(1));
  assign any   = |req;
endmodule

// File: rtl/rx_queue.sv
module rx_queue #(
  parameter int DEPTH = 64,
  parameter int W     = 12,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push && !full) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop && !empty) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      count <= count + CW'(push && !full) - CW'(pop && !empty);
    end
  end
endmodule

// File: rtl/term_rx_queue.sv
module term_rx_queue
  import term_rx_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16,
  localparam int CW         = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        scan_en,
  input  logic        rx_ie,
  input  logic        alarm_ie,
  input  logic        lpr_wr,
  input  logic [15:0] lpr_data,
  input  logic [7:0]  line_valid,
  input  logic [63:0] line_char,
  input  logic [7:0]  line_brk,
  input  logic        rbuf_rd,
  output logic [15:0] rbuf_data,
  output logic        done,
  output logic        alarm,
  output logic        overflow,
  output logic        rx_irq
);
  logic [NLINES-1:0]        pend_v, pend_brk, grant;
  logic [NLINES*CHAR_W-1:0] pend_char;
  logic [LINE_W-1:0]        sel;
  logic                     pend_any;
  rx_ent_t                  wr_ent, head;
  logic [CW-1:0]            count, count_nxt;
  logic                     full, empty;

  // named internal events
  logic enq_ev, drop_ev, pop_ev, alarm_set_ev, rearm_ev, armed;

  rx_line_slots #(.NL(NLINES)) u_slots (
    .clk(clk), .rst_n(rst_n), .clr(clr), .scan_en(scan_en),
    .lpr_wr(lpr_wr), .lpr_line(lpr_data[LINE_W-1:0]), .lpr_en(lpr_data[12]),
    .line_valid(line_valid), .line_char(line_char), .line_brk(line_brk),
    .grant(grant), .pend_v(pend_v), .pend_char(pend_char), .pend_brk(pend_brk)
  );

  rx_pick_lowest #(.NL(NLINES)) u_pick (
    .req(pend_v), .grant(grant), .idx(sel), .any(pend_any)
  );

  assign wr_ent.brk  = pend_brk[sel];
  assign wr_ent.line = sel;
  assign wr_ent.ch   = pend_char[sel*CHAR_W +: CHAR_W];

  rx_queue #(.DEPTH(DEPTH), .W(ENT_W)) u_q (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(enq_ev), .wdata(wr_ent),
    .pop(pop_ev), .rdata(head), .count(count), .full(full), .empty(empty)
  );

  assign enq_ev       = pend_any && !full && !clr;
  assign drop_ev      = pend_any && full && !clr;
  assign pop_ev       = rbuf_rd && scan_en && !empty && !clr;
  assign rearm_ev     = rbuf_rd && scan_en && empty;
  assign count_nxt    = count + CW'(enq_ev) - CW'(pop_ev);
  assign alarm_set_ev = armed && !clr && level_reached(count_nxt, ALARM_LEVEL);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rbuf_data <= '0;
      alarm     <= 1'b0;
      overflow  <= 1'b0;
      armed     <= 1'b1;
    end else begin
      if (rbuf_rd) rbuf_data <= pop_ev ? rbuf_word(head) : 16'h0000;
      if (alarm_set_ev)  alarm <= 1'b1;
      else if (rbuf_rd)  alarm <= 1'b0;
      if (alarm_set_ev)  armed <= 1'b0;
      else if (rearm_ev) armed <= 1'b1;
      if (drop_ev) overflow <= 1'b1;
    end
  end

  assign done   = scan_en && !empty;
  assign rx_irq = rx_ie && (alarm_ie ? alarm : done);
endmodule

// File: rtl/term_rx_queue_chk.sv
module term_rx_queue_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          scan_en,
  input logic          rbuf_rd,
  input logic [15:0]   rbuf_data,
  input logic          done,
  input logic          alarm,
  input logic          overflow,
  input logic          armed,
  input logic          alarm_set_ev,
  input logic [CW-1:0] count
);
  // R7: a rising alarm needs the armed state one cycle earlier
  a_r7_alarm_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(armed));
  // R7: once fired, the alarm is disarmed
  a_r7_disarm_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> !armed);
  // R8: a read without a simultaneous set leaves the alarm low
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rbuf_rd && !alarm_set_ev |=> !alarm);
  // R9: read with scan off yields zero
  a_r9_scan_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rbuf_rd && !scan_en && !clr |=> rbuf_data == 16'h0000);
  // R6: no done while scan is off
  a_r6_done_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> !done);
  // R11: overflow is sticky until clear
  a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clr |=> overflow);
  // R11: occupancy never exceeds depth
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

bind term_rx_queue term_rx_queue_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .scan_en(scan_en), .rbuf_rd(rbuf_rd),
  .rbuf_data(rbuf_data), .done(done), .alarm(alarm), .overflow(overflow),
  .armed(armed), .alarm_set_ev(alarm_set_ev), .count(count)
);

// File: tb/term_rx_queue_tb.sv
module term_rx_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, scan_en = 1'b0, rx_ie = 1'b0, alarm_ie = 1'b0;
  logic        lpr_wr = 1'b0;
  logic [15:0] lpr_data = '0;
  logic [7:0]  line_valid = '0, line_brk = '0;
  logic [63:0] line_char = '0;
  logic        rbuf_rd = 1'b0;
  logic [15:0] rbuf_data;
  logic        done, alarm, overflow, rx_irq;

  always #4 clk = ~clk;

  term_rx_queue u_dut (.*);

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  // reference model
  logic [15:0] exp_q[$];
  bit [7:0] m_en = '0;
  bit m_alarm = 0, m_armed = 1, m_ovf = 0;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic check_status(input string tag);
    bit e_done, e_irq;
    e_done = scan_en && (exp_q.size() > 0);
    e_irq  = rx_ie && (alarm_ie ? m_alarm : e_done);
    check(done == e_done, {tag, " R6 done"}, 16'(done), 16'(e_done));
    check(alarm == m_alarm, {tag, " R7/R8 alarm"}, 16'(alarm), 16'(m_alarm));
    check(overflow == m_ovf, {tag, " R11 overflow"}, 16'(overflow), 16'(m_ovf));
    check(rx_irq == e_irq, {tag, " R10 irq"}, 16'(rx_irq), 16'(e_irq));
  endtask

  task automatic lpr(input int line, input bit en);
    @(negedge clk);
    lpr_wr = 1'b1;
    lpr_data = 16'(line) | (en ? 16'h1000 : 16'h0000);
    @(negedge clk);
    lpr_wr = 1'b0;
    m_en[line] = en;
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    exp_q.delete(); m_en = '0; m_alarm = 0; m_ovf = 0; m_armed = 1;
  endtask

  // driver: strobes lines in mask, pushes expected words in ascending line order
  task automatic send(input bit [7:0] mask, input bit [7:0] brk, input bit [7:0] base);
    int n = 0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      line_char[i*8 +: 8] = base + 8'(i);
      if (mask[i] && m_en[i] && scan_en) begin
        n++;
        if (exp_q.size() < 64) begin
          exp_q.push_back(brk[i] ? (16'hA000 | (16'(i) << 8))
                                 : (16'h8000 | (16'(i) << 8) | 16'(base + 8'(i))));
          if (m_armed && exp_q.size() >= 16) begin m_alarm = 1; m_armed = 0; end
        end else m_ovf = 1;
      end
    end
    line_valid = mask; line_brk = brk;
    @(negedge clk);
    line_valid = '0; line_brk = '0;
    repeat (n > 0 ? n : 1) @(negedge clk);
  endtask

  // monitor: reads and compares with the scoreboard head
  task automatic read_check(input string tag);
    logic [15:0] e;
    @(negedge clk); rbuf_rd = 1'b1;
    @(negedge clk); rbuf_rd = 1'b0;
    m_alarm = 0;
    if (!scan_en) e = 16'h0000;
    else if (exp_q.size() == 0) begin e = 16'h0000; m_armed = 1; end
    else e = exp_q.pop_front();
    check(rbuf_data == e, tag, rbuf_data, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rbuf_data == 16'h0, "R5 reset word", rbuf_data, 16'h0);
    check_status("reset");
    scan_en = 1'b1; rx_ie = 1'b1;

    // R3: disabled line ignored
    send(8'h04, 8'h00, 8'h30);
    check_status("R3 disabled line");
    for (int i = 0; i < 8; i++) lpr(i, 1'b1);

    // R1 normal char, R6/R10 done as irq source
    send(8'h08, 8'h00, 8'h3E);
    check_status("R1 one char");
    read_check("R1 word line 3");
    check_status("R6 after drain");
    // R5: read word holds
    repeat (3) @(negedge clk);
    check(rbuf_data == 16'h8341, "R5 hold", rbuf_data, 16'h8341);

    // R2 break
    send(8'h20, 8'h20, 8'h55);
    read_check("R2 break line 5");

    // R4 same-cycle arrivals
    send(8'h52, 8'h00, 8'h60);
    check_status("R4 multi");
    read_check("R4 first lowest");
    read_check("R4 second");
    read_check("R4 third");

    // R3 disable line 1
    lpr(1, 1'b0);
    send(8'h02, 8'h00, 8'h10);
    check_status("R3 line1 off");

    // R7/R8 alarm behaviour, alarm as irq source
    alarm_ie = 1'b1;
    for (int k = 0; k < 15; k++) send(8'h01, 8'h00, 8'(k));
    check_status("R7 below level");
    send(8'h01, 8'h00, 8'h70);
    check_status("R7 at level");
    read_check("R8 read under alarm");
    check_status("R8 alarm cleared");
    send(8'h01, 8'h00, 8'h71);
    check_status("R7 disarmed refill");
    while (exp_q.size() > 0) read_check("R5 fifo order");
    read_check("R8 empty read rearms");
    for (int k = 0; k < 16; k++) send(8'h80, 8'h00, 8'(k));
    check_status("R8 re-armed fires");

    // R9 scan disabled
    scan_en = 1'b0;
    @(negedge clk);
    check_status("R9 scan off");
    read_check("R9 zero read");
    send(8'h80, 8'h00, 8'h00);
    scan_en = 1'b1;
    @(negedge clk);
    check_status("R9 kept entries");
    read_check("R9 entry not popped");

    // R12 clear
    do_clr();
    check(rbuf_data == 16'h0, "R12 word zero", rbuf_data, 16'h0);
    check_status("R12 cleared");
    send(8'h01, 8'h00, 8'h00);
    check_status("R12 R3 enables dropped");

    // R11 overflow
    lpr(0, 1'b1);
    alarm_ie = 1'b0;
    for (int k = 0; k < 65; k++) send(8'h01, 8'h00, 8'(k));
    check_status("R11 full");
    for (int k = 0; k < 64; k++) read_check("R11 kept entry");
    read_check("R11 empty after 64");
    check_status("R11 drained");
    do_clr();
    check_status("R11 R12 overflow cleared");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule